// File: doc/BRIEF.md
# Opcode Class and Length Decoder

This block is the first decode stage of a small 8-bit processor core that runs a subset of a classic 8-bit instruction set. It looks at the opcode byte already captured in the first instruction-byte latch. From that byte alone, and with no clock, it works out which kind of instruction the byte is. The result is a one-hot class vector and two flags for memory operands. The block also passes the register and function fields of the opcode straight through.

The same decode tells the cycle sequencer how many bytes remain to be fetched and how many execute cycles to run. An opcode that falls in no class, such as the no-operation code 00h, leaves every class output low. It then gets the shortest schedule: a single-byte fetch and one execute cycle.

Top module: `opc_decode`

## Requirements
- R1: When opcode bits 7:6 are 01, the byte is a move. Bits 2:0 equal to 110 give a move from memory. Otherwise, bits 5:3 equal to 110 give a move to memory. Any other such byte is a register move. The single exception is 76h, which decodes as halt.
- R2: When bits 7:6 are 10, the byte is a memory ALU op if bits 2:0 are 110, and a register ALU op otherwise. `alu_fn_o` always equals opcode bits 5:3. Its codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare.
- R3: A byte of the form 11FFF110 decodes as an immediate ALU op.
- R4: A byte of the form 00DDD110 decodes as a move immediate. It targets memory when DDD is 110 (byte 36h) and a register otherwise.
- R5: 3Ah decodes as load accumulator direct and 32h as store accumulator direct. 23h decodes as HL increment and 2Bh as HL decrement.
- R6: `mem_src_o` is high exactly for a move from memory and a memory ALU op. `mem_dst_o` is high exactly for a move to memory and a move immediate to memory.
- R7: `dst_sel_o` always equals opcode bits 5:3 and `src_sel_o` always equals opcode bits 2:0.
- R8: `fetch2_o` is high for both move immediates and for immediate ALU ops. `fetch3_o` is high for load and store direct. The two flags are never high together, and both are low for every other opcode.
- R9: `exec2_o` is high for register, memory and immediate ALU ops and for HL increment and decrement. It is low for every other opcode.
- R10: An opcode matching no class, including 00h, drives `class_o` to all zeros with `fetch2_o`, `fetch3_o` and `exec2_o` low.
- R11: The bit positions of `class_o` are: 0 register move, 1 move from memory, 2 move to memory, 3 move immediate to register, 4 move immediate to memory, 5 register ALU, 6 memory ALU, 7 immediate ALU, 8 load direct, 9 store direct, 10 HL increment, 11 HL decrement, 12 halt. At most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte from the first instruction latch |
| class_o | output | 13 | One-hot instruction class, bit positions as in R11 |
| dst_sel_o | output | 3 | Destination register select (opcode bits 5:3) |
| src_sel_o | output | 3 | Source register select (opcode bits 2:0) |
| alu_fn_o | output | 3 | ALU function select (opcode bits 5:3) |
| mem_src_o | output | 1 | Operand source is the byte addressed by HL |
| mem_dst_o | output | 1 | Result destination is the byte addressed by HL |
| fetch2_o | output | 1 | Instruction is two bytes long |
| fetch3_o | output | 1 | Instruction is three bytes long |
| exec2_o | output | 1 | Instruction needs a second execute cycle |

## Verification
The decoder is first driven with hand-picked bytes. These include 3Eh against 36h, which separates the two move-immediate targets by the 110 destination code. They also include 46h, 70h and 76h, where the source code, the destination code and the halt exception each win inside the move group. C6h against FEh checks that the immediate function field reaches the ALU select. The direct load/store bytes and the HL step bytes are checked against their near neighbours 08h and 00h, which must fall through to the default schedule. A sweep of all 256 byte values then compares every output with an independent model. This sweep shows that no unlisted byte picks up a class or a longer schedule.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int OPC_W = 8;
  localparam int FLD_W = 3;
  localparam logic [FLD_W-1:0] MEM_CODE = 3'b110;

  localparam int CL_MOV_RR = 0;
  localparam int CL_MOV_RM = 1;
  localparam int CL_MOV_MR = 2;
  localparam int CL_MVI_R  = 3;
  localparam int CL_MVI_M  = 4;
  localparam int CL_ALU_R  = 5;
  localparam int CL_ALU_M  = 6;
  localparam int CL_ALU_I  = 7;
  localparam int CL_LDA    = 8;
  localparam int CL_STA    = 9;
  localparam int CL_INX    = 10;
  localparam int CL_DCX    = 11;
  localparam int CL_HLT    = 12;
  localparam int CL_N      = 13;

  localparam logic [OPC_W-1:0] OP_HLT = 8'h76;
  localparam logic [OPC_W-1:0] OP_LDA = 8'h3A;
  localparam logic [OPC_W-1:0] OP_STA = 8'h32;
  localparam logic [OPC_W-1:0] OP_INX = 8'h23;
  localparam logic [OPC_W-1:0] OP_DCX = 8'h2B;

  typedef struct packed {
    logic mov_grp;
    logic alu_grp;
    logic imm_grp;
    logic mvi_grp;
    logic src_mem;
    logic dst_mem;
    logic hlt;
    logic lda;
    logic sta;
    logic inx;
    logic dcx;
  } grp_t;
endpackage

// File: rtl/opc_group_dec.sv
module opc_group_dec
  import opc_pkg::*;
#(
  parameter int W = OPC_W
) (
  input  logic [W-1:0] opcode_i,
  output grp_t         grp_o
);
  localparam int PFX_LO = W - 2;

  logic [1:0]       pfx;
  logic [FLD_W-1:0] dst;
  logic [FLD_W-1:0] src;

  assign pfx = opcode_i[W-1:PFX_LO];
  assign dst = opcode_i[2*FLD_W-1:FLD_W];
  assign src = opcode_i[FLD_W-1:0];

  always_comb begin
    grp_o         = '0;
    grp_o.hlt     = (opcode_i == OP_HLT);
    grp_o.lda     = (opcode_i == OP_LDA);
    grp_o.sta     = (opcode_i == OP_STA);
    grp_o.inx     = (opcode_i == OP_INX);
    grp_o.dcx     = (opcode_i == OP_DCX);
    grp_o.src_mem = (src == MEM_CODE);
    grp_o.dst_mem = (dst == MEM_CODE);
    grp_o.mov_grp = (pfx == 2'b01) && !grp_o.hlt;
    grp_o.alu_grp = (pfx == 2'b10);
    grp_o.imm_grp = (pfx == 2'b11) && grp_o.src_mem;
    grp_o.mvi_grp = (pfx == 2'b00) && grp_o.src_mem;
  end
endmodule

// File: rtl/opc_class_dec.sv
module opc_class_dec
  import opc_pkg::*;
#(
  parameter int N = CL_N
) (
  input  grp_t         grp_i,
  output logic [N-1:0] class_o
);
  always_comb begin
    class_o = '0;
    if (grp_i.hlt) class_o[CL_HLT] = 1'b1;
    else if (grp_i.mov_grp) begin
      // source code wins over destination code
      if (grp_i.src_mem)      class_o[CL_MOV_RM] = 1'b1;
      else if (grp_i.dst_mem) class_o[CL_MOV_MR] = 1'b1;
      else                    class_o[CL_MOV_RR] = 1'b1;
    end
    else if (grp_i.alu_grp) begin
      if (grp_i.src_mem) class_o[CL_ALU_M] = 1'b1;
      else               class_o[CL_ALU_R] = 1'b1;
    end
    else if (grp_i.imm_grp) class_o[CL_ALU_I] = 1'b1;
    else if (grp_i.mvi_grp) begin
      if (grp_i.dst_mem) class_o[CL_MVI_M] = 1'b1;
      else               class_o[CL_MVI_R] = 1'b1;
    end
    else if (grp_i.lda) class_o[CL_LDA] = 1'b1;
    else if (grp_i.sta) class_o[CL_STA] = 1'b1;
    else if (grp_i.inx) class_o[CL_INX] = 1'b1;
    else if (grp_i.dcx) class_o[CL_DCX] = 1'b1;
  end
endmodule

// File: rtl/opc_len_dec.sv
module opc_len_dec
  import opc_pkg::*;
#(
  parameter int N = CL_N
) (
  input  logic [N-1:0] class_i,
  output logic         fetch2_o,
  output logic         fetch3_o,
  output logic         exec2_o,
  output logic         mem_src_o,
  output logic         mem_dst_o
);
  assign fetch2_o  = class_i[CL_MVI_R] | class_i[CL_MVI_M] | class_i[CL_ALU_I];
  assign fetch3_o  = class_i[CL_LDA] | class_i[CL_STA];
  assign exec2_o   = class_i[CL_ALU_R] | class_i[CL_ALU_M] | class_i[CL_ALU_I]
                   | class_i[CL_INX] | class_i[CL_DCX];
  assign mem_src_o = class_i[CL_MOV_RM] | class_i[CL_ALU_M];
  assign mem_dst_o = class_i[CL_MOV_MR] | class_i[CL_MVI_M];
endmodule

// File: rtl/opc_decode.sv
module opc_decode
  import opc_pkg::*;
#(
  parameter int W = OPC_W,
  parameter int N = CL_N
) (
  input  logic [W-1:0]     opcode_i,
  output logic [N-1:0]     class_o,
  output logic [FLD_W-1:0] dst_sel_o,
  output logic [FLD_W-1:0] src_sel_o,
  output logic [FLD_W-1:0] alu_fn_o,
  output logic             mem_src_o,
  output logic             mem_dst_o,
  output logic             fetch2_o,
  output logic             fetch3_o,
  output logic             exec2_o
);
  localparam int DST_LO = FLD_W;
  localparam int DST_HI = 2*FLD_W - 1;

  grp_t grp;

  opc_group_dec #(.W(W)) u_grp (
    .opcode_i (opcode_i),
    .grp_o    (grp)
  );

  opc_class_dec #(.N(N)) u_cls (
    .grp_i   (grp),
    .class_o (class_o)
  );

  opc_len_dec #(.N(N)) u_len (
    .class_i   (class_o),
    .fetch2_o  (fetch2_o),
    .fetch3_o  (fetch3_o),
    .exec2_o   (exec2_o),
    .mem_src_o (mem_src_o),
    .mem_dst_o (mem_dst_o)
  );

  // fields go to register array and ALU unchanged
  assign dst_sel_o = opcode_i[DST_HI:DST_LO];
  assign src_sel_o = opcode_i[FLD_W-1:0];
  assign alu_fn_o  = opcode_i[DST_HI:DST_LO];
endmodule

// File: rtl/opc_decode_chk.sv
module opc_decode_chk
  import opc_pkg::*;
(
  input logic [OPC_W-1:0] opcode_i,
  input logic [CL_N-1:0]  class_o,
  input logic [FLD_W-1:0] dst_sel_o,
  input logic [FLD_W-1:0] src_sel_o,
  input logic             mem_src_o,
  input logic             mem_dst_o,
  input logic             fetch2_o,
  input logic             fetch3_o,
  input logic             exec2_o
);
  always_comb begin
    // R11
    class_onehot_chk: assert ($onehot0(class_o));
    // R8
    fetch_excl_chk: assert (!(fetch2_o && fetch3_o));
    // R10
    no_class_short_chk: assert ((class_o != '0) || !(fetch2_o || fetch3_o || exec2_o));
    // R1
    halt_code_chk: assert ((opcode_i != OP_HLT) || class_o[CL_HLT]);
    // R6
    mem_src_code_chk: assert (!mem_src_o || (src_sel_o == MEM_CODE));
    // R6
    mem_dst_code_chk: assert (!mem_dst_o || (dst_sel_o == MEM_CODE));
  end
endmodule

bind opc_decode opc_decode_chk u_chk (
  .opcode_i  (opcode_i),
  .class_o   (class_o),
  .dst_sel_o (dst_sel_o),
  .src_sel_o (src_sel_o),
  .mem_src_o (mem_src_o),
  .mem_dst_o (mem_dst_o),
  .fetch2_o  (fetch2_o),
  .fetch3_o  (fetch3_o),
  .exec2_o   (exec2_o)
);

// File: tb/opc_decode_bench.sv
module opc_decode_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  opcode;
  logic [12:0] cls;
  logic [2:0]  dst_sel, src_sel, alu_fn;
  logic        mem_src, mem_dst, fetch2, fetch3, exec2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opc_decode u_opc_decode (
    .opcode_i  (opcode),
    .class_o   (cls),
    .dst_sel_o (dst_sel),
    .src_sel_o (src_sel),
    .alu_fn_o  (alu_fn),
    .mem_src_o (mem_src),
    .mem_dst_o (mem_dst),
    .fetch2_o  (fetch2),
    .fetch3_o  (fetch3),
    .exec2_o   (exec2)
  );

  typedef struct {
    logic [7:0]  op;
    logic [12:0] cls;
    logic        f2, f3, e2, ms, md;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(logic [7:0] op);
    exp_t e;
    e.op = op; e.cls = '0; e.f2 = 0; e.f3 = 0; e.e2 = 0; e.ms = 0; e.md = 0;
    e.tag = "R10";
    if (op == 8'h76) begin e.cls[12] = 1; e.tag = "R1"; end
    else if (op[7:6] == 2'b01) begin
      e.tag = "R1";
      if (op[2:0] == 3'd6)      begin e.cls[1] = 1; e.ms = 1; end
      else if (op[5:3] == 3'd6) begin e.cls[2] = 1; e.md = 1; end
      else e.cls[0] = 1;
    end else if (op[7:6] == 2'b10) begin
      e.tag = "R2"; e.e2 = 1;
      if (op[2:0] == 3'd6) begin e.cls[6] = 1; e.ms = 1; end
      else e.cls[5] = 1;
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'd6) begin
      e.tag = "R3"; e.cls[7] = 1; e.f2 = 1; e.e2 = 1;
    end else if (op[7:6] == 2'b00 && op[2:0] == 3'd6) begin
      e.tag = "R4"; e.f2 = 1;
      if (op == 8'h36) begin e.cls[4] = 1; e.md = 1; end
      else e.cls[3] = 1;
    end else begin
      case (op)
        8'h3A: begin e.cls[8]  = 1; e.f3 = 1; e.tag = "R5"; end
        8'h32: begin e.cls[9]  = 1; e.f3 = 1; e.tag = "R5"; end
        8'h23: begin e.cls[10] = 1; e.e2 = 1; e.tag = "R5"; end
        8'h2B: begin e.cls[11] = 1; e.e2 = 1; e.tag = "R5"; end
        default: ;
      endcase
    end
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] op, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%02h actual=%0h expected=%0h", req, op, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] op);
    @(negedge clk);
    opcode = op;
    q.push_back(model(op));
  endtask

  // monitor: outputs settle half a cycle after the negedge drive
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(cls === e.cls, e.tag, e.op, {3'b0, cls}, {3'b0, e.cls});
      chk($countones(cls) <= 1, "R11", e.op, {3'b0, cls}, 16'd1);
      chk({fetch2, fetch3} === {e.f2, e.f3}, "R8", e.op, {14'b0, fetch2, fetch3}, {14'b0, e.f2, e.f3});
      chk(exec2 === e.e2, "R9", e.op, {15'b0, exec2}, {15'b0, e.e2});
      chk({mem_src, mem_dst} === {e.ms, e.md}, "R6", e.op, {14'b0, mem_src, mem_dst}, {14'b0, e.ms, e.md});
      chk({dst_sel, src_sel} === {e.op[5:3], e.op[2:0]}, "R7", e.op, {10'b0, dst_sel, src_sel}, {10'b0, e.op[5:0]});
      chk(alu_fn === e.op[5:3], "R2", e.op, {13'b0, alu_fn}, {13'b0, e.op[5:3]});
    end
  end

  initial begin
    opcode = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state: NOP held on the input, no class and short schedule
    chk(cls === '0 && !fetch2 && !fetch3 && !exec2, "R10", opcode,
        {3'b0, cls}, 16'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    // directed corner bytes
    drive(8'h3E); drive(8'h36); drive(8'h46); drive(8'h70); drive(8'h76);
    drive(8'h78); drive(8'h86); drive(8'h80); drive(8'hBF); drive(8'hC6);
    drive(8'hFE); drive(8'h3A); drive(8'h32); drive(8'h23); drive(8'h2B);
    drive(8'h08); drive(8'h00); drive(8'h33);
    for (int i = 0; i < 256; i++) drive(i[7:0]);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule